// File: doc/BRIEF.md
# Fractional Clock-Enable Rate Controller

This block turns one fast input clock into per-subsystem clock-enable strobes at reduced, software-selected rates. It serves two processor subsystems. The input clock first passes through a fixed divide-by-two. Each subsystem then gets its own fraction of that divided rate, in steps of 1/32, and the enable strobes are spread evenly by a phase accumulator. Downstream clock gating consumes these strobes. The gating cells themselves are outside this block.

Software programs a 5-bit code for each subsystem through a small memory-mapped register port. The code is an inverted fraction: the multiplier is 32 minus the code, so a code of 0 means full rate. Programmed codes are held in shadow storage and have no effect on the outputs yet. Software then sets a kick bit. Hardware moves the shadow codes into the active settings at the next 32-tick window boundary, and clears the kick bit on the following cycle. While the kick bit reads 1, an update is in progress. A further kick written during that time neither restarts nor delays the update.

Top module: `frac_clk_en_ctrl`

## Requirements
- R1: After reset both codes read 0, the kick bit reads 0, and each enable output asserts 32 times in every 64 input cycles.
- R2: The rate register sits at offset 0x808. Subsystem 0's code is at bits 4:0 and subsystem 1's code is at bits 12:8. All other bits read 0, and a read returns the last written codes.
- R3: With code c, an enable output asserts exactly 32-c times in any 64 consecutive input cycles once that code is active. Codes 0 to 31 give multipliers 32 down to 1.
- R4: The fixed divide-by-two means an enable output is never high on two consecutive input cycles.
- R5: A write to the rate register leaves the enable outputs at their previous rates until a kick completes.
- R6: The kick register sits at offset 0x804, with the kick at bit 31. Writing 1 there makes the bit read 1. Hardware clears it within 70 input cycles, on the cycle after the new codes are loaded. All other bits of this register read 0.
- R7: The active codes change only at a 32-tick window boundary.
- R8: A kick written while the kick bit is still 1 neither restarts nor extends the update in progress.
- R9: Writing 0 to bit 31 of the kick register has no effect. Writes to any other offset change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| en_o | output | 2 | Clock-enable strobe per subsystem |

## Verification
The assertions are checked on every cycle. They cover these properties:
- Enables are never high on back-to-back cycles.
- Each completed window holds exactly as many enables as the active multiplier.
- Active codes move only at window boundaries.
- The kick bit stays set until the load and clears on the very next cycle.

The bench scenarios cover what the assertions cannot see at the ports:
- The register layout and readback.
- Isolation of the shadow codes until a kick.
- Completion latency seen by a polling reader, including a repeated kick.
- The full sweep of all 32 codes for both subsystems at once.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int unsigned CODE_W      = 5;
  localparam int unsigned ADDR_W      = 12;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned LANE_STRIDE = 8;
  localparam int unsigned KICK_BIT    = 31;
  localparam logic [ADDR_W-1:0] OFS_KICK = 12'h804;
  localparam logic [ADDR_W-1:0] OFS_RATE = 12'h808;
endpackage

// File: rtl/fcr_window.sv
module fcr_window #(
  parameter int unsigned PREDIV = 2,
  parameter int unsigned CODE_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic wrap_o
);
  localparam int unsigned PRE_W = (PREDIV > 1) ? $clog2(PREDIV) : 1;
  localparam int unsigned WIN   = 2 ** CODE_W;

  logic [PRE_W-1:0]  pre_q;
  logic [CODE_W-1:0] win_q;

  assign tick_o = (pre_q == PRE_W'(PREDIV - 1));
  assign wrap_o = tick_o && (win_q == CODE_W'(WIN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      win_q <= '0;
    end else begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
      if (tick_o) win_q <= win_q + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R4
endmodule

// File: rtl/fcr_regs.sv
module fcr_regs
  import fcr_pkg::*;
#(
  parameter int unsigned N_SUB = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  input  logic                         wrap_i,
  output logic [N_SUB-1:0][CODE_W-1:0] code_o
);
  logic [N_SUB-1:0][CODE_W-1:0] shadow_q, active_q;
  logic kick_q, done_q;
  logic wr_rate, wr_kick;

  assign wr_rate = we_i && (addr_i == OFS_RATE);
  assign wr_kick = we_i && (addr_i == OFS_KICK) && wdata_i[KICK_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (wr_rate) begin
      for (int i = 0; i < N_SUB; i++)
        shadow_q[i] <= wdata_i[i*LANE_STRIDE +: CODE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      done_q   <= 1'b0;
      kick_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (wrap_i && kick_q && !done_q) begin
        active_q <= shadow_q;
        done_q   <= 1'b1;
      end
      if (done_q)       kick_q <= 1'b0;
      else if (wr_kick) kick_q <= 1'b1;  // re-kick while busy: no effect
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_RATE) begin
      for (int i = 0; i < N_SUB; i++)
        rdata_o[i*LANE_STRIDE +: CODE_W] = shadow_q[i];
    end else if (addr_i == OFS_KICK) begin
      rdata_o[KICK_BIT] = kick_q;
    end
  end

  assign code_o = active_q;

  AST_ACTIVE_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wrap_i) |-> $stable(active_q)); // R7
  AST_KICK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_q && !done_q) |=> kick_q); // R8
  AST_KICK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !kick_q); // R6
endmodule

// File: rtl/fcr_pulse.sv
module fcr_pulse #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wrap_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              en_o
);
  localparam int unsigned WIN = 2 ** CODE_W;

  logic [CODE_W-1:0] acc_q;
  logic [CODE_W:0]   mult;
  logic [CODE_W+1:0] sum;
  logic              carry;
  logic              en_q;

  assign mult  = (CODE_W+1)'(WIN) - {1'b0, code_i};
  assign sum   = {2'b00, acc_q} + {1'b0, mult};
  assign carry = |sum[CODE_W+1:CODE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= tick_i && carry;
      if (tick_i) acc_q <= sum[CODE_W-1:0];
    end
  end

  assign en_o = en_q;

  // window occupancy counter used only by the check below
  logic [CODE_W:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (tick_i) seen_q <= wrap_i ? '0 : seen_q + (CODE_W+1)'(carry);
  end

  AST_WINDOW_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && wrap_i) |-> (seen_q + (CODE_W+1)'(carry) == mult)); // R3
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> !en_o); // R4
  AST_FULL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && code_i == '0) |=> en_o); // R1
endmodule

// File: rtl/frac_clk_en_ctrl.sv
module frac_clk_en_ctrl
  import fcr_pkg::*;
#(
  parameter int unsigned N_SUB  = 2,
  parameter int unsigned PREDIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_SUB-1:0]  en_o
);
  logic tick, wrap;
  logic [N_SUB-1:0][CODE_W-1:0] code;

  fcr_window #(.PREDIV(PREDIV), .CODE_W(CODE_W)) u_window (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick), .wrap_o(wrap));

  fcr_regs #(.N_SUB(N_SUB)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .wrap_i(wrap), .code_o(code));

  for (genvar g = 0; g < N_SUB; g++) begin : g_sub
    fcr_pulse #(.CODE_W(CODE_W)) u_pulse (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .wrap_i(wrap),
      .code_i(code[g]), .en_o(en_o[g]));
  end
endmodule

// File: tb/frac_clk_en_ctrl_tb_top.sv
module frac_clk_en_ctrl_tb_top;
  localparam logic [11:0] A_KICK = 12'h804;
  localparam logic [11:0] A_RATE = 12'h808;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  en;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  frac_clk_en_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .en_o(en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #2 d = rdata;
  endtask

  task automatic count64(output int c0, output int c1, output bit adj);
    logic [1:0] prev = '0;
    c0 = 0; c1 = 0; adj = 1'b0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk); #3;
      c0 += int'(en[0]); c1 += int'(en[1]);
      if ((en & prev) != 0) adj = 1'b1;
      prev = en;
    end
  endtask

  task automatic wait_kick(output int cyc);
    logic [31:0] d;
    cyc = 0;
    for (int k = 0; k < 200; k++) begin
      rd(A_KICK, d);
      if (!d[31]) break;
      cyc++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c0, c1, cyc, pm0, pm1;
    bit adj;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(A_RATE, d); chk(d == 0, "R1 rate reset", int'(d), 0);
    rd(A_KICK, d); chk(d == 0, "R1 kick reset", int'(d), 0);
    count64(c0, c1, adj);
    chk(c0 == 32, "R1 sub0 full rate", c0, 32);
    chk(c1 == 32, "R1 sub1 full rate", c1, 32);
    chk(!adj, "R4 no back-to-back", int'(adj), 0);

    pm0 = 32; pm1 = 32;
    for (int c = 0; c < 32; c++) begin
      wr(A_RATE, 32'hFFFF_E0E0 | 32'(c) | (32'(31 - c) << 8));
      rd(A_RATE, d);
      chk(d == (32'(c) | (32'(31 - c) << 8)), "R2 readback layout", int'(d),
          int'(32'(c) | (32'(31 - c) << 8)));
      count64(c0, c1, adj);
      chk(c0 == pm0 && c1 == pm1, "R5 no effect before kick", c0 * 100 + c1, pm0 * 100 + pm1);
      wr(A_KICK, 32'h8000_0000);
      rd(A_KICK, d); chk(d == 32'h8000_0000, "R6 kick reads busy", int'(d), 32'h8000_0000);
      wait_kick(cyc); chk(cyc <= 70, "R6 kick clears", cyc, 70);
      count64(c0, c1, adj);
      chk(c0 == 32 - c, "R3 sub0 rate", c0, 32 - c);
      chk(c1 == c + 1, "R3 sub1 rate", c1, c + 1);
      chk(!adj, "R4 no back-to-back", int'(adj), 0);
      pm0 = 32 - c; pm1 = c + 1;
    end

    // R8: repeated kick while busy
    wr(A_RATE, 32'h0000_0A05);
    wr(A_KICK, 32'h8000_0000);
    repeat (10) @(negedge clk);
    wr(A_KICK, 32'h8000_0000);
    wait_kick(cyc);
    chk(cyc + 12 <= 70, "R8 re-kick no extension", cyc + 12, 70);
    count64(c0, c1, adj);
    chk(c0 == 27 && c1 == 22, "R8 rates after re-kick", c0 * 100 + c1, 2722);

    // R9: kick write of 0 and stray address writes
    wr(A_KICK, 32'h7FFF_FFFF);
    rd(A_KICK, d); chk(d == 0, "R9 zero kick ignored", int'(d), 0);
    wr(12'h800, 32'hFFFF_FFFF);
    wr(12'h80C, 32'hFFFF_FFFF);
    rd(A_RATE, d); chk(d == 32'h0000_0A05, "R9 stray write rate", int'(d), 32'h0A05);
    rd(A_KICK, d); chk(d == 0, "R9 stray write kick", int'(d), 0);
    count64(c0, c1, adj);
    chk(c0 == 27 && c1 == 22, "R9 rates unchanged", c0 * 100 + c1, 2722);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule